// File: doc/BRIEF.md
# Frame Sync Acquisition State Machine

This block aligns a receiver to a continuous stream of back-to-back frames that arrive one bit at a time. Each frame opens with a fixed sync word. The receiver does not know where the frames begin. The block watches a sliding window of the most recent bits and compares it with the sync word. It acquires alignment in two steps: it first finds a candidate, then sees the word repeat one frame later. It holds alignment through isolated corrupted sync words and declares loss only after a run of consecutive misses.

Downstream logic uses three outputs. The lock flag gates payload handling. The frame-start strobe marks the last bit of each expected sync word. The state code reports how far acquisition has progressed.

Frame length (in bits), sync word width and the number of consecutive misses that drop lock are parameters. The sync word itself is a configuration input. Only bits accompanied by the valid strobe count for any purpose.

Top module: `frame_sync_acq`

## Requirements
- R1: After reset the state output is 0 (searching) and the lock output is low.
- R2: While searching, every valid bit is tested. The window holds the last SYNC_W valid bits, with the oldest bit compared to the sync word's most significant bit. A match moves the state to 1 (confirming). A match needs at least SYNC_W valid bits since reset.
- R3: In confirming, only the valid bit exactly FRAME_LEN valid bits after the matching bit is tested. A match there moves to state 2 (locked), and a mismatch moves to state 0. Matches at other positions are ignored.
- R4: In locked, the test happens once per frame at the expected position. A match keeps state 2. Sync words that appear at any other position have no effect.
- R5: A mismatch at the expected position in locked moves to state 3 (loss check), and the lock output stays high.
- R6: In loss check, a match at the expected position returns to state 2 and restarts the count of consecutive misses.
- R7: When MAX_MISS consecutive expected positions have mismatched, counting the one that left state 2, the state returns to 0 and lock drops.
- R8: A cycle with the valid input low changes neither the state nor the window, and does not advance the frame position count.
- R9: The frame-start output is high, in the same cycle, exactly when a valid bit falls on an expected sync position in state 2 or 3. This holds whether or not that bit matches.
- R10: The lock output is high exactly in states 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | Qualifies bitIn |
| syncWord | input | SYNC_W | Sync word, first-sent bit in the MSB |
| locked | output | 1 | Alignment held |
| frameStart | output | 1 | Expected sync position in states 2 and 3 |
| stateOut | output | 2 | 0 search, 1 confirm, 2 locked, 3 loss check |

## Verification
The frame-start strobe and a loss declaration can fall in the same cycle. The final missed sync in state 3 still raises frame start while the state moves to 0. The bench provokes this by corrupting MAX_MISS sync words in a row after lock. A behavioural model of bit history and expected positions then judges both outputs in that cycle. The model also judges the state after the edge. A second coincidence is a sync word planted in the payload while locked. That word matches the window on a non-expected bit, and the bench checks that neither the state nor frame start responds to it.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCK    = 2'd2,
    ST_LOSS    = 2'd3
  } syncState_t;

  // Strobes from control to datapath, already qualified by bitValid.
  typedef struct packed {
    logic restartPhase;
    logic clearMiss;
    logic bumpMiss;
  } ctrlStrobe_t;

  // Observations from datapath to control for the current bit.
  typedef struct packed {
    logic hit;
    logic due;
    logic missLimit;
  } dpStatus_t;
endpackage

// File: rtl/frame_sync_datapath.sv
module frame_sync_datapath
  import frame_sync_pkg::*;
#(
  parameter int SYNC_W    = 8,
  parameter int FRAME_LEN = 32,
  parameter int MAX_MISS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [SYNC_W-1:0] syncWord,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);
  localparam int PH_W   = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int FILL_W = $clog2(SYNC_W);
  localparam int MISS_W = $clog2(MAX_MISS + 1);
  localparam int MISS_LIMIT = (MAX_MISS >= 2) ? MAX_MISS - 2 : 0;
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(FRAME_LEN - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SYNC_W - 1);

  logic [SYNC_W-1:0] window;
  logic [SYNC_W-1:0] nextWindow;
  logic [FILL_W-1:0] fillCnt;
  logic [PH_W-1:0]   phase;
  logic [MISS_W-1:0] missCnt;
  logic              filled;

  assign nextWindow = {window[SYNC_W-2:0], bitIn};
  assign filled     = (fillCnt == FILL_FULL);

  assign status.hit       = filled && (nextWindow == syncWord);
  assign status.due       = (phase == PH_LAST);
  assign status.missLimit = (missCnt == MISS_W'(MISS_LIMIT));

  // Sliding window and fill count advance on valid bits only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      window  <= '0;
      fillCnt <= '0;
    end else if (bitValid) begin
      window <= nextWindow;
      if (!filled) fillCnt <= fillCnt + 1'b1;
    end
  end

  // Bits elapsed since the last (expected) sync end; wraps each frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (bitValid) begin
      if (strobe.restartPhase || status.due) phase <= '0;
      else                                   phase <= phase + 1'b1;
    end
  end

  // Misses seen while in the loss-check state.
  always_ff @(posedge clk) begin
    if (!rstN)                 missCnt <= '0;
    else if (strobe.clearMiss) missCnt <= '0;
    else if (strobe.bumpMiss)  missCnt <= missCnt + 1'b1;
  end
endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl
  import frame_sync_pkg::*;
#(
  parameter int MAX_MISS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output syncState_t  state,
  output logic        frameStart,
  output logic        locked
);
  syncState_t nextState;
  logic       check;

  assign check = bitValid && status.due;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_SEARCH: begin
        if (bitValid && status.hit) begin
          nextState           = ST_CONFIRM;
          strobe.restartPhase = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (check) begin
          if (status.hit) begin
            nextState        = ST_LOCK;
            strobe.clearMiss = 1'b1;
          end else begin
            nextState = ST_SEARCH;
          end
        end
      end
      ST_LOCK: begin
        if (check && !status.hit) begin
          strobe.clearMiss = 1'b1;
          nextState        = (MAX_MISS <= 1) ? ST_SEARCH : ST_LOSS;
        end
      end
      ST_LOSS: begin
        if (check) begin
          if (status.hit) begin
            nextState        = ST_LOCK;
            strobe.clearMiss = 1'b1;
          end else if (status.missLimit) begin
            nextState = ST_SEARCH;
          end else begin
            strobe.bumpMiss = 1'b1;
          end
        end
      end
      default: nextState = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= nextState;
  end

  assign locked     = (state == ST_LOCK) || (state == ST_LOSS);
  assign frameStart = check && locked;
endmodule

// File: rtl/frame_sync_acq.sv
module frame_sync_acq
  import frame_sync_pkg::*;
#(
  parameter int SYNC_W    = 8,
  parameter int FRAME_LEN = 32,
  parameter int MAX_MISS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [SYNC_W-1:0] syncWord,
  output logic              locked,
  output logic              frameStart,
  output logic [1:0]        stateOut
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  syncState_t  state;

  frame_sync_datapath #(
    .SYNC_W(SYNC_W), .FRAME_LEN(FRAME_LEN), .MAX_MISS(MAX_MISS)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .syncWord(syncWord), .strobe(strobe), .status(status)
  );

  frame_sync_ctrl #(
    .MAX_MISS(MAX_MISS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .status(status),
    .strobe(strobe), .state(state), .frameStart(frameStart),
    .locked(locked)
  );

  assign stateOut = state;
endmodule

// File: rtl/frame_sync_acq_chk.sv
module frame_sync_acq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       locked,
  input logic       frameStart,
  input logic [1:0] stateOut
);
  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(stateOut));

  // R9
  frame_start_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (locked && bitValid));

  // R2
  search_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd0) |=> (stateOut inside {2'd0, 2'd1}));

  // R10
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(stateOut) == 2'd1));

  // R6
  loss_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd3) |=> (stateOut != 2'd1));
endmodule

bind frame_sync_acq frame_sync_acq_chk uChk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .locked(locked),
  .frameStart(frameStart), .stateOut(stateOut)
);

// File: tb/sim_frame_sync_acq.sv
module sim_frame_sync_acq;
  localparam int SYNC_W    = 8;
  localparam int FRAME_LEN = 32;
  localparam int MAX_MISS  = 3;
  localparam logic [SYNC_W-1:0] SYNC = 8'hB5;

  logic clk = 1'b0;
  logic rstN, bitIn, bitValid, locked, frameStart;
  logic [SYNC_W-1:0] syncWord;
  logic [1:0] stateOut;

  always #5 clk = ~clk;

  frame_sync_acq #(.SYNC_W(SYNC_W), .FRAME_LEN(FRAME_LEN), .MAX_MISS(MAX_MISS)) u0 (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .syncWord(syncWord), .locked(locked), .frameStart(frameStart),
    .stateOut(stateOut)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // Behavioural reference: bit history, absolute bit index, next expected index.
  bit hist[$];
  int mState = 0;
  int bitIdx = 0;
  int nextExp = 0;
  int misses = 0;

  task automatic checkVal(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  function automatic bit histMatch();
    if (hist.size() < SYNC_W) return 1'b0;
    for (int i = 0; i < SYNC_W; i++)
      if (hist[i] != SYNC[SYNC_W-1-i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic driveBit(bit b, bit v);
    bit due;
    bit m;
    @(negedge clk);
    checkVal("state", int'(stateOut), mState);
    checkVal("locked", int'(locked), (mState >= 2) ? 1 : 0);
    bitIn = b;
    bitValid = v;
    #1;
    if (v) begin
      bitIdx++;
      hist.push_back(b);
      if (hist.size() > SYNC_W) void'(hist.pop_front());
    end
    due = v && (mState != 0) && (bitIdx == nextExp);
    checkVal("frameStart", int'(frameStart), (due && mState >= 2) ? 1 : 0);
    if (v) begin
      m = histMatch();
      if (mState == 0) begin
        if (m) begin mState = 1; nextExp = bitIdx + FRAME_LEN; end
      end else if (due) begin
        nextExp = bitIdx + FRAME_LEN;
        case (mState)
          1: mState = m ? 2 : 0;
          2: if (!m) begin mState = (MAX_MISS <= 1) ? 0 : 3; misses = 1; end
          default: begin
            if (m) begin mState = 2; misses = 0; end
            else if (misses + 1 >= MAX_MISS) mState = 0;
            else misses++;
          end
        endcase
      end
    end
  endtask

  task automatic expectState(int s);
    @(negedge clk);
    bitValid = 1'b0;
    checkVal("directed state", int'(stateOut), s);
    checkVal("directed locked", int'(locked), (s >= 2) ? 1 : 0);
  endtask

  // One frame: sync (good or inverted), zero payload, optional planted word, optional gaps.
  task automatic sendFrame(bit goodSync, bit fake, int gapEvery);
    bit b;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (i < SYNC_W) b = goodSync ? SYNC[SYNC_W-1-i] : ~SYNC[SYNC_W-1-i];
      else if (fake && i >= 12 && i < 12 + SYNC_W) b = SYNC[SYNC_W-1-(i-12)];
      else b = 1'b0;
      if (gapEvery > 0 && (i % gapEvery) == 0) driveBit(1'b1, 1'b0);
      driveBit(b, 1'b1);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; bitIn = 1'b0; bitValid = 1'b0; syncWord = SYNC;
    repeat (3) @(posedge clk);
    curReq = "R1";
    expectState(0);
    @(negedge clk) rstN = 1'b1;
    expectState(0);

    // R3: lone sync, no repeat one frame later
    curReq = "R3";
    for (int i = 0; i < 10; i++) driveBit(1'b0, 1'b1);
    sendFrame(1'b1, 1'b0, 0);
    expectState(1);
    sendFrame(1'b0, 1'b0, 0);
    expectState(0);

    // R2, R4: acquire on clean frames
    curReq = "R2";
    for (int i = 0; i < 5; i++) driveBit(1'b0, 1'b1);
    sendFrame(1'b1, 1'b0, 0);
    expectState(1);
    curReq = "R4";
    sendFrame(1'b1, 1'b0, 0);
    expectState(2);
    sendFrame(1'b1, 1'b1, 0);
    sendFrame(1'b1, 1'b1, 0);
    expectState(2);

    // R8: valid gaps do not shift alignment
    curReq = "R8";
    sendFrame(1'b1, 1'b0, 3);
    sendFrame(1'b1, 1'b0, 5);
    expectState(2);

    // R5, R6: single miss then recovery
    curReq = "R5";
    sendFrame(1'b0, 1'b0, 0);
    expectState(3);
    curReq = "R6";
    sendFrame(1'b1, 1'b0, 0);
    expectState(2);
    curReq = "R5";
    sendFrame(1'b0, 1'b0, 0);
    sendFrame(1'b0, 1'b0, 0);
    expectState(3);
    curReq = "R6";
    sendFrame(1'b1, 1'b0, 0);
    expectState(2);

    // R7, R9: MAX_MISS consecutive misses; frame start coincides with loss
    curReq = "R7";
    for (int k = 0; k < MAX_MISS; k++) sendFrame(1'b0, 1'b0, 0);
    expectState(0);

    // R9, R10: random stream compared bit by bit against the model
    curReq = "R9";
    for (int i = 0; i < 400; i++) driveBit(1'($urandom_range(1)), 1'($urandom_range(3) != 0));
    curReq = "R10";
    for (int k = 0; k < 4; k++) sendFrame(1'b1, 1'b1, 0);
    expectState(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule